// File: doc/BRIEF.md
# CPU Clock Frequency Slew Controller

This block produces the frequency control word for a CPU clock synthesizer. A three-bit select input chooses one of eight target frequencies held in a small table. Software or boot logic fills that table through a load port. When the accepted select changes, the block does not jump to the new value. Instead, on every tick from an external timebase it moves the word toward the target by a bounded step. This keeps the rate of frequency change low enough for downstream phase-locked loops to stay locked.

The word is an unsigned count in kHz. It always stays between a floor and a ceiling, both set by parameters. A select value is accepted only after it has been held for several consecutive clock samples, so short glitches on the select pins are ignored. After reset, the settled flag stays low for a fixed number of ticks to cover the initial lock interval. After that, it is high whenever the word equals the active target.

A typical use is to let the power manager lower the CPU clock smoothly by changing the select pins. The frequency then ramps at a rate between 1 and 20 MHz per millisecond when the tick period is 1 µs.

Top module: `freq_slew_ctrl`

## Requirements
- R1: Reset state: `freqWord` equals FLOOR_KHZ (20000), `settled` is 0, every table entry holds FLOOR_KHZ, and the accepted select is 0.
- R2: A new `cpuSel` value is accepted at the clock edge that takes its STABLE_CYC-th (4) consecutive equal sample. A value held for fewer samples is ignored and does not move `freqWord`.
- R3: `freqWord` changes only on a clock edge where `tick` is 1. On such an edge it moves toward the active target by the step size. If the remaining distance is smaller than the step, it lands exactly on the target and never overshoots.
- R4: The step size used is `stepKhz` clamped to the range STEP_MIN..STEP_MAX (1..20 kHz per tick), so a value of 0 moves 1 and a value above 20 moves 20.
- R5: A loaded target below FLOOR_KHZ is stored as FLOOR_KHZ, and one above CEIL_KHZ (100000) is stored as CEIL_KHZ. The new entry takes effect on the next cycle.
- R6: If the accepted select changes during a ramp, the ramp turns at once toward the new target, starting from the current word. It does not return to the old target first.
- R7: `settled` is 1 exactly when LOCK_TICKS (50) ticks have elapsed since reset and `freqWord` equals the active target.
- R8: `freqWord` never leaves the range FLOOR_KHZ..CEIL_KHZ, and it changes by at most STEP_MAX per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 3 | Target select |
| tick | input | 1 | Timebase tick, one ramp step per cycle high |
| stepKhz | input | 8 | Requested step size in kHz per tick |
| loadEn | input | 1 | Write strobe for the target table |
| loadIdx | input | 3 | Table entry to write |
| loadKhz | input | 18 | Target value in kHz, clamped on write |
| freqWord | output | 18 | Current frequency word in kHz |
| settled | output | 1 | Lock interval over and word at target |

## Verification
Each tick moves the word, and the new value is visible in the cycle after the tick edge. A table write becomes the target one cycle after its strobe. A select change becomes the active target at the edge of its fourth equal sample, so the ramp toward it starts at the first tick after that edge. `settled` is decoded from registered state, so it follows the word in the same cycle. The bench changes inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. On every falling edge it compares the word and the flag with that model. The directed checks count the ticks that were actually applied between samples, which lets them predict exact ramp distances and end points.

// File: rtl/slew_pkg.sv
package slew_pkg;
  typedef struct packed {
    logic stepNow;    // apply one ramp step this cycle
    logic lockValid;  // power-up lock interval elapsed
  } slewCtrlT;
endpackage

// File: rtl/slew_target_table.sv
module slew_target_table #(
  parameter int SEL_W     = 3,
  parameter int WORD_W    = 18,
  parameter int FLOOR_KHZ = 20000,
  parameter int CEIL_KHZ  = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadIdx,
  input  logic [WORD_W-1:0] loadKhz,
  input  logic [SEL_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData
);
  localparam int NUM_TGT = 1 << SEL_W;
  localparam logic [WORD_W-1:0] FLOOR_W = WORD_W'(FLOOR_KHZ);
  localparam logic [WORD_W-1:0] CEIL_W  = WORD_W'(CEIL_KHZ);

  logic [WORD_W-1:0] entries [NUM_TGT];
  logic [WORD_W-1:0] loadClamped;

  always_comb begin
    if (loadKhz < FLOOR_W)     loadClamped = FLOOR_W;
    else if (loadKhz > CEIL_W) loadClamped = CEIL_W;
    else                       loadClamped = loadKhz;
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   entries[g] <= FLOOR_W;
      else if (loadEn && loadIdx == SEL_W'(g))     entries[g] <= loadClamped;
    end
  end

  assign rdData = entries[rdIdx];

  // R5
  table_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData >= FLOOR_W && rdData <= CEIL_W);
endmodule

// File: rtl/slew_sequencer.sv
module slew_sequencer import slew_pkg::*; #(
  parameter int SEL_W      = 3,
  parameter int STABLE_CYC = 4,
  parameter int LOCK_TICKS = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] cpuSel,
  input  logic             tick,
  output slewCtrlT         ctrl,
  output logic [SEL_W-1:0] actSel
);
  localparam int CNT_W  = $clog2(STABLE_CYC + 1);
  localparam int LOCK_W = $clog2(LOCK_TICKS + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(STABLE_CYC);
  localparam logic [CNT_W-1:0]  CNT_ACC  = CNT_W'(STABLE_CYC - 1);
  localparam logic [LOCK_W-1:0] LOCK_MAX = LOCK_W'(LOCK_TICKS);

  logic [SEL_W-1:0]  candSel;
  logic [CNT_W-1:0]  runCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic              sameSel;

  assign sameSel = (cpuSel == candSel);

  // Debounce: a select value must be seen STABLE_CYC samples in a row.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candSel <= '0;
      runCnt  <= CNT_MAX;
      actSel  <= '0;
    end else if (!sameSel) begin
      candSel <= cpuSel;
      runCnt  <= CNT_W'(1);
    end else begin
      if (runCnt < CNT_MAX) runCnt <= runCnt + CNT_W'(1);
      if (runCnt >= CNT_ACC) actSel <= candSel;
    end
  end

  // Power-up lock interval counted in timebase ticks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lockCnt <= '0;
    else if (tick && lockCnt < LOCK_MAX) lockCnt <= lockCnt + LOCK_W'(1);
  end

  assign ctrl.stepNow   = tick;
  assign ctrl.lockValid = (lockCnt == LOCK_MAX);

  // R2
  accept_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actSel != $past(actSel)) |-> (actSel == $past(cpuSel)));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lockValid |=> ctrl.lockValid);
endmodule

// File: rtl/slew_datapath.sv
module slew_datapath import slew_pkg::*; #(
  parameter int SEL_W     = 3,
  parameter int WORD_W    = 18,
  parameter int RATE_W    = 8,
  parameter int FLOOR_KHZ = 20000,
  parameter int CEIL_KHZ  = 100000,
  parameter int STEP_MIN  = 1,
  parameter int STEP_MAX  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  slewCtrlT          ctrl,
  input  logic [SEL_W-1:0]  actSel,
  input  logic [RATE_W-1:0] stepKhz,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadIdx,
  input  logic [WORD_W-1:0] loadKhz,
  output logic [WORD_W-1:0] word,
  output logic              atTarget
);
  localparam logic [WORD_W-1:0] FLOOR_W = WORD_W'(FLOOR_KHZ);
  localparam logic [WORD_W-1:0] CEIL_W  = WORD_W'(CEIL_KHZ);
  localparam logic [RATE_W-1:0] SMIN_R  = RATE_W'(STEP_MIN);
  localparam logic [RATE_W-1:0] SMAX_R  = RATE_W'(STEP_MAX);
  localparam logic [WORD_W-1:0] SMAX_W  = WORD_W'(STEP_MAX);

  logic [WORD_W-1:0] target;
  logic [RATE_W-1:0] stepClamp;
  logic [WORD_W-1:0] stepW, gap, move, nextWord;
  logic              goingUp;

  slew_target_table #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .FLOOR_KHZ(FLOOR_KHZ), .CEIL_KHZ(CEIL_KHZ)
  ) i_table (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadKhz(loadKhz), .rdIdx(actSel), .rdData(target)
  );

  always_comb begin
    if (stepKhz < SMIN_R)      stepClamp = SMIN_R;
    else if (stepKhz > SMAX_R) stepClamp = SMAX_R;
    else                       stepClamp = stepKhz;
    stepW    = WORD_W'(stepClamp);
    goingUp  = (target >= word);
    gap      = goingUp ? (target - word) : (word - target);
    move     = (gap < stepW) ? gap : stepW;
    nextWord = goingUp ? (word + move) : (word - move);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             word <= FLOOR_W;
    else if (ctrl.stepNow) word <= nextWord;
  end

  assign atTarget = (word == target);

  // R8
  word_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    word >= FLOOR_W && word <= CEIL_W);

  // R8
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((word >= $past(word)) ? (word - $past(word)) : ($past(word) - word)) <= SMAX_W);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.stepNow) |-> $stable(word));
endmodule

// File: rtl/freq_slew_ctrl.sv
module freq_slew_ctrl import slew_pkg::*; #(
  parameter int SEL_W      = 3,
  parameter int WORD_W     = 18,
  parameter int RATE_W     = 8,
  parameter int FLOOR_KHZ  = 20000,
  parameter int CEIL_KHZ   = 100000,
  parameter int STEP_MIN   = 1,
  parameter int STEP_MAX   = 20,
  parameter int STABLE_CYC = 4,
  parameter int LOCK_TICKS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  cpuSel,
  input  logic              tick,
  input  logic [RATE_W-1:0] stepKhz,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadIdx,
  input  logic [WORD_W-1:0] loadKhz,
  output logic [WORD_W-1:0] freqWord,
  output logic              settled
);
  slewCtrlT         ctrl;
  logic [SEL_W-1:0] actSel;
  logic             atTarget;

  slew_sequencer #(
    .SEL_W(SEL_W), .STABLE_CYC(STABLE_CYC), .LOCK_TICKS(LOCK_TICKS)
  ) i_seq (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .tick(tick),
    .ctrl(ctrl), .actSel(actSel)
  );

  slew_datapath #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .RATE_W(RATE_W),
    .FLOOR_KHZ(FLOOR_KHZ), .CEIL_KHZ(CEIL_KHZ),
    .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .actSel(actSel), .stepKhz(stepKhz),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadKhz(loadKhz),
    .word(freqWord), .atTarget(atTarget)
  );

  assign settled = ctrl.lockValid & atTarget;
endmodule

// File: tb/test_freq_slew_ctrl.sv
module test_freq_slew_ctrl;
  localparam int FLOOR = 20000;
  localparam int CEIL  = 100000;
  localparam int SMIN  = 1;
  localparam int SMAX  = 20;
  localparam int STAB  = 4;
  localparam int LOCK  = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cpuSel = '0;
  logic        tick = 1'b0;
  logic [7:0]  stepKhz = 8'd20;
  logic        loadEn = 1'b0;
  logic [2:0]  loadIdx = '0;
  logic [17:0] loadKhz = '0;
  logic [17:0] freqWord;
  logic        settled;

  int checks = 0;
  int fails  = 0;
  int tickCnt = 0;
  bit tickOn = 1'b0;
  bit phase  = 1'b0;
  bit done   = 1'b0;

  // behavioural reference state
  int mTbl[8];
  int mWord, mAct, mRunVal, mRunLen, mLock;

  always #5 clk = ~clk;

  freq_slew_ctrl i_freq_slew_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .tick(tick), .stepKhz(stepKhz),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadKhz(loadKhz),
    .freqWord(freqWord), .settled(settled)
  );

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mTbl[i]) mTbl[i] = FLOOR;
      mWord = FLOOR; mAct = 0; mRunVal = 0; mRunLen = STAB; mLock = 0;
    end else begin
      if (tick) begin
        int tgt, st;
        tgt = mTbl[mAct];
        st  = clampI(int'(stepKhz), SMIN, SMAX);
        if (mWord < tgt)      mWord = mWord + ((tgt - mWord < st) ? tgt - mWord : st);
        else if (mWord > tgt) mWord = mWord - ((mWord - tgt < st) ? mWord - tgt : st);
        if (mLock < LOCK) mLock++;
      end
      if (loadEn) mTbl[loadIdx] = clampI(int'(loadKhz), FLOOR, CEIL);
      if (int'(cpuSel) == mRunVal) begin
        if (mRunLen < STAB) mRunLen++;
      end else begin
        mRunVal = int'(cpuSel); mRunLen = 1;
      end
      if (mRunLen >= STAB) mAct = mRunVal;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expSet;
      expSet = (mLock == LOCK) && (mWord == mTbl[mAct]);
      chk(int'(freqWord) == mWord, "R3 word vs model", int'(freqWord), mWord);
      chk(settled == expSet, "R7 settled vs model", int'(settled), int'(expSet));
      chk(int'(freqWord) >= FLOOR && int'(freqWord) <= CEIL, "R8 range",
          int'(freqWord), FLOOR);
    end
  end

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      if (tick) tickCnt++;
      @(negedge clk);
      phase = ~phase;
      tick  = tickOn && phase;
    end
  endtask

  task automatic loadTgt(int idx, int val);
    loadEn = 1'b1; loadIdx = 3'(idx); loadKhz = 18'(val);
    run(1);
    loadEn = 1'b0;
  endtask

  initial begin
    int w0, t0, w1;
    repeat (3) @(negedge clk);
    chk(int'(freqWord) == FLOOR, "R1 reset word", int'(freqWord), FLOOR);
    chk(settled == 1'b0, "R1 reset settled", int'(settled), 0);
    rstN = 1'b1;
    tickOn = 1'b1;
    run(120);
    chk(settled == 1'b1, "R7 settled after lock interval", int'(settled), 1);
    chk(int'(freqWord) == FLOOR, "R1 entry 0 holds floor", int'(freqWord), FLOOR);

    loadTgt(1, 200000);
    loadTgt(2, 5000);
    loadTgt(3, 50000);
    loadTgt(4, 20010);

    // short glitch on the select must be ignored
    cpuSel = 3'd1; run(STAB - 1);
    cpuSel = 3'd0; run(20);
    chk(int'(freqWord) == FLOOR, "R2 glitch ignored", int'(freqWord), FLOOR);

    // oversize step clamps to maximum
    stepKhz = 8'd200;
    cpuSel = 3'd1; run(8);
    w0 = int'(freqWord); t0 = tickCnt;
    run(20);
    chk(int'(freqWord) - w0 == SMAX * (tickCnt - t0), "R4 step clamp high",
        int'(freqWord) - w0, SMAX * (tickCnt - t0));
    // zero step clamps to minimum
    stepKhz = 8'd0;
    w0 = int'(freqWord); t0 = tickCnt;
    run(20);
    chk(int'(freqWord) - w0 == SMIN * (tickCnt - t0), "R4 step clamp low",
        int'(freqWord) - w0, SMIN * (tickCnt - t0));

    // ramp past 60000, then retarget downward to 50000
    stepKhz = 8'd20;
    run(4200);
    chk(int'(freqWord) > 60000, "R6 ramp progressed", int'(freqWord), 60000);
    cpuSel = 3'd3; run(10);
    w1 = int'(freqWord);
    run(10);
    chk(int'(freqWord) < w1, "R6 turns toward new target", int'(freqWord), w1);
    run(4000);
    chk(int'(freqWord) == 50000, "R6 reaches new target", int'(freqWord), 50000);
    chk(settled == 1'b1, "R7 settled at new target", int'(settled), 1);

    // clamped entries: ceiling and floor
    cpuSel = 3'd1; run(6000);
    chk(int'(freqWord) == CEIL, "R5 over-range load clamped to ceiling", int'(freqWord), CEIL);
    cpuSel = 3'd2; run(9000);
    chk(int'(freqWord) == FLOOR, "R5 under-range load clamped to floor", int'(freqWord), FLOOR);

    // no tick, no motion
    tickOn = 1'b0; cpuSel = 3'd1; run(40);
    chk(int'(freqWord) == FLOOR, "R3 no change without tick", int'(freqWord), FLOOR);
    chk(settled == 1'b0, "R7 not settled away from target", int'(settled), 0);

    // saturating final step: 20000 -> 20010 with step 20
    cpuSel = 3'd4; run(8);
    tickOn = 1'b1; run(10);
    chk(int'(freqWord) == 20010, "R3 lands on target without overshoot", int'(freqWord), 20010);

    // second reset restarts the lock interval and clears the table
    rstN = 1'b0; tickOn = 1'b0; run(3);
    chk(int'(freqWord) == FLOOR, "R1 word after second reset", int'(freqWord), FLOOR);
    chk(settled == 1'b0, "R1 settled after second reset", int'(settled), 0);
    rstN = 1'b1; tickOn = 1'b1; cpuSel = 3'd0;
    run(40);
    chk(settled == 1'b0, "R7 still inside lock interval", int'(settled), 0);
    run(80);
    chk(settled == 1'b1, "R7 lock interval over", int'(settled), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog (R1..all) actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule